// File: doc/BRIEF.md
# I2C Controller Interrupt Status and Vector Unit

This block gathers the event flags of a byte-oriented I2C master controller and turns them into one level-sensitive interrupt line and two DMA request lines. The transfer engine reports each event as a single-cycle set pulse. The unit stores every pulse as a sticky status bit. Status bits that are enabled in the interrupt-enable register raise the interrupt line. The DMA register picks which ready flags drive the receive and transmit DMA requests.

Software reads a vector register to service the interrupt. The read returns the 1-based index of the lowest pending enabled event, and the same read acknowledges that event by clearing its status bit. When the controller enable is dropped, a global clear input returns all state to zero. Register access uses a simple synchronous port with word offsets and 16-bit data. A read returns its data combinationally in the cycle `regRdEn` is high. A write takes effect at the clock edge that ends that cycle.

Register offsets (word offsets on `regAddr`): 0 revision, 1 interrupt enable, 2 status, 3 vector, 4 DMA. An unmapped offset reads as zero.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset, the status, interrupt-enable and DMA registers read 0, `irqOut`, `rxDmaReq` and `txDmaReq` are low, and offset 0 reads 0x0011.
- R2: A high bit of `evtSet` sets the matching status bit at the next edge, and the bit stays set. Only bits 1 (no-ack), 2 (access ready), 3 (receive ready), 4 (transmit ready), 9 (addressed as slave), 10 (transmit underflow), 11 (receive overrun) and 15 (single byte) exist. Other bits read 0, except bit 12 of the status read, which is the live `busBusy` input.
- R3: `irqOut` is high exactly when the status value AND the interrupt-enable value is nonzero.
- R4: A write to offset 1 keeps only bits 4..0. The other bits read back as 0.
- R5: A write to offset 4 keeps only bit 15 (receive DMA enable) and bit 7 (transmit DMA enable). Writing 1 to bit 15 clears enable bit 3, and writing 1 to bit 7 clears enable bit 4.
- R6: `rxDmaReq` equals status bit 3 while DMA bit 15 is set, and `txDmaReq` equals status bit 4 while DMA bit 7 is set. Each request is low while its enable bit is 0.
- R7: A read of offset 3 returns one plus the position of the lowest set bit of (status AND enable), or 0 if no such bit is set. That status bit is cleared at the end of the read cycle.
- R8: If a set pulse and a vector-read acknowledge hit the same status bit in the same cycle, the bit stays set.
- R9: Writes to offsets 0, 2 and 3 change no state.
- R10: A pulse on `clrAll` returns the status, interrupt-enable and DMA registers to 0 at the next edge. It takes priority over set pulses in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clrAll | input | 1 | Synchronous global clear, asserted when the controller is disabled |
| evtSet | input | 16 | Single-cycle status set pulses, one per status bit position |
| busBusy | input | 1 | Live bus-busy flag, merged into status read bit 12 |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 4 | Register word offset |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data, valid while regRdEn is high |
| irqOut | output | 1 | Level interrupt request |
| rxDmaReq | output | 1 | Receive DMA request |
| txDmaReq | output | 1 | Transmit DMA request |

## Verification
The hardest state to reach from the ports is the race between an acknowledge and a new event on the same bit. The bench first makes receive-ready the only pending enabled event. It then raises that bit's set pulse in the same cycle as a vector read, and afterwards checks through a status read that the bit survived. The vector priority order is checked by setting every event at once and acknowledging the events one at a time. Between acknowledges, status reads show which bit each read removed. The DMA-enable side effect is observed at the ports: the enable register is read back, and the interrupt and DMA request lines are watched while the ready flags are still pending.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  // status bit positions; software decodes these
  localparam int BIT_NACK = 1;
  localparam int BIT_ARDY = 2;
  localparam int BIT_RRDY = 3;
  localparam int BIT_XRDY = 4;
  localparam int BIT_AAS  = 9;
  localparam int BIT_XUDF = 10;
  localparam int BIT_ROVR = 11;
  localparam int BIT_BUSY = 12;
  localparam int BIT_SBD  = 15;

  // DMA enable bit positions
  localparam int RX_DMA_BIT = 15;
  localparam int TX_DMA_BIT = 7;

  // register word offsets
  localparam int OFF_REV  = 0;
  localparam int OFF_MASK = 1;
  localparam int OFF_STAT = 2;
  localparam int OFF_VEC  = 3;
  localparam int OFF_DMA  = 4;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_REV,
    SEL_MASK,
    SEL_STAT,
    SEL_VEC,
    SEL_DMA
  } rdsel_t;

  typedef struct packed {
    logic wrMask;
    logic wrDma;
    logic rdVector;
    logic clrAll;
  } irqv_strobe_t;

endpackage

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
  import irqv_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              clrAll,
  output irqv_strobe_t      strobes,
  output rdsel_t            rdSel
);

  logic isMask, isDma, isVec, isStat, isRev;

  assign isRev  = (regAddr == ADDR_W'(OFF_REV));
  assign isMask = (regAddr == ADDR_W'(OFF_MASK));
  assign isStat = (regAddr == ADDR_W'(OFF_STAT));
  assign isVec  = (regAddr == ADDR_W'(OFF_VEC));
  assign isDma  = (regAddr == ADDR_W'(OFF_DMA));

  // writes to revision, status and vector offsets produce no strobe
  always_comb begin
    strobes.wrMask   = regWrEn & isMask;
    strobes.wrDma    = regWrEn & isDma;
    strobes.rdVector = regRdEn & isVec;
    strobes.clrAll   = clrAll;
  end

  always_comb begin
    rdSel = SEL_NONE;
    if (regRdEn) begin
      if (isRev)       rdSel = SEL_REV;
      else if (isMask) rdSel = SEL_MASK;
      else if (isStat) rdSel = SEL_STAT;
      else if (isVec)  rdSel = SEL_VEC;
      else if (isDma)  rdSel = SEL_DMA;
    end
  end

endmodule

// File: rtl/irqv_datapath.sv
module irqv_datapath
  import irqv_pkg::*;
#(
  parameter int          DATA_W  = 16,
  parameter int          MASK_W  = 5,
  parameter logic [15:0] REV_VAL = 16'h0011
) (
  input  logic              clk,
  input  logic              rstN,
  input  irqv_strobe_t      strobes,
  input  rdsel_t            rdSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] evtSet,
  input  logic              busBusy,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              rxDmaReq,
  output logic              txDmaReq,
  output logic [DATA_W-1:0] statusQ,
  output logic [MASK_W-1:0] maskQ,
  output logic [DATA_W-1:0] dmaQ
);

  localparam int VEC_W = $clog2(MASK_W + 1);
  localparam logic [DATA_W-1:0] STAT_IMPL =
      DATA_W'((1 << BIT_NACK) | (1 << BIT_ARDY) | (1 << BIT_RRDY) |
              (1 << BIT_XRDY) | (1 << BIT_AAS)  | (1 << BIT_XUDF) |
              (1 << BIT_ROVR) | (1 << BIT_SBD));
  localparam logic [DATA_W-1:0] DMA_KEEP =
      DATA_W'((1 << RX_DMA_BIT) | (1 << TX_DMA_BIT));
  localparam int NUM_CH = 2;

  logic [MASK_W-1:0] pend;
  logic [MASK_W-1:0] ackOh;
  logic [VEC_W-1:0]  vecIdx;
  logic [DATA_W-1:0] statusD;
  logic [MASK_W-1:0] maskD;
  logic [DATA_W-1:0] dmaD;
  logic [NUM_CH-1:0] dmaReq;

  // pending, enabled events and the lowest one
  assign pend  = statusQ[MASK_W-1:0] & maskQ;
  assign ackOh = pend & (~pend + MASK_W'(1));

  always_comb begin
    vecIdx = '0;
    for (int i = MASK_W - 1; i >= 0; i--) begin
      if (pend[i]) vecIdx = VEC_W'(i + 1);
    end
  end

  // status: acknowledge first, then set pulses override, clear overrides all
  always_comb begin
    statusD = statusQ;
    if (strobes.rdVector)
      statusD[MASK_W-1:0] = statusQ[MASK_W-1:0] & ~ackOh;
    statusD = (statusD | evtSet) & STAT_IMPL;
    if (strobes.clrAll) statusD = '0;
  end

  always_comb begin
    maskD = maskQ;
    if (strobes.wrMask) maskD = wrData[MASK_W-1:0];
    if (strobes.wrDma) begin
      if (wrData[RX_DMA_BIT]) maskD[BIT_RRDY] = 1'b0;
      if (wrData[TX_DMA_BIT]) maskD[BIT_XRDY] = 1'b0;
    end
    if (strobes.clrAll) maskD = '0;
  end

  always_comb begin
    dmaD = dmaQ;
    if (strobes.wrDma) dmaD = wrData & DMA_KEEP;
    if (strobes.clrAll) dmaD = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '0;
      dmaQ    <= '0;
    end else begin
      statusQ <= statusD;
      maskQ   <= maskD;
      dmaQ    <= dmaD;
    end
  end

  // one DMA request channel per direction
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_dma
    localparam int EN_BIT = (ch == 0) ? RX_DMA_BIT : TX_DMA_BIT;
    localparam int ST_BIT = (ch == 0) ? BIT_RRDY : BIT_XRDY;
    assign dmaReq[ch] = dmaQ[EN_BIT] & statusQ[ST_BIT];
  end

  assign rxDmaReq = dmaReq[0];
  assign txDmaReq = dmaReq[1];
  assign irqOut   = |pend;

  always_comb begin
    rdData = '0;
    unique case (rdSel)
      SEL_REV:  rdData = DATA_W'(REV_VAL);
      SEL_MASK: rdData = DATA_W'(maskQ);
      SEL_STAT: begin
        rdData = statusQ;
        rdData[BIT_BUSY] = busBusy;
      end
      SEL_VEC:  rdData = DATA_W'(vecIdx);
      SEL_DMA:  rdData = dmaQ;
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irqv_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int MASK_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clrAll,
  input  logic [DATA_W-1:0] evtSet,
  input  logic              busBusy,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut,
  output logic              rxDmaReq,
  output logic              txDmaReq
);

  irqv_strobe_t      strobes;
  rdsel_t            rdSel;
  logic [DATA_W-1:0] statusQ;
  logic [MASK_W-1:0] maskQ;
  logic [DATA_W-1:0] dmaQ;

  irqv_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .clrAll  (clrAll),
    .strobes (strobes),
    .rdSel   (rdSel)
  );

  irqv_datapath #(.DATA_W(DATA_W), .MASK_W(MASK_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .rdSel    (rdSel),
    .wrData   (regWrData),
    .evtSet   (evtSet),
    .busBusy  (busBusy),
    .rdData   (regRdData),
    .irqOut   (irqOut),
    .rxDmaReq (rxDmaReq),
    .txDmaReq (txDmaReq),
    .statusQ  (statusQ),
    .maskQ    (maskQ),
    .dmaQ     (dmaQ)
  );

endmodule

// File: rtl/irq_vector_unit_chk.sv
module irq_vector_unit_chk
  import irqv_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int MASK_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              clrAll,
  input logic [DATA_W-1:0] evtSet,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic              irqOut,
  input logic              rxDmaReq,
  input logic              txDmaReq,
  input logic [DATA_W-1:0] statusQ,
  input logic [MASK_W-1:0] maskQ
);

  logic rdVec, rdMask, wrDma;
  assign rdVec  = regRdEn && (regAddr == ADDR_W'(OFF_VEC));
  assign rdMask = regRdEn && (regAddr == ADDR_W'(OFF_MASK));
  assign wrDma  = regWrEn && (regAddr == ADDR_W'(OFF_DMA));

  // R2: set pulses are captured and held
  p_set_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!clrAll && (evtSet != '0)) |=>
      ((statusQ & $past(evtSet)) == ($past(evtSet) & statusQ | $past(evtSet) & statusQ))
      && (($past(evtSet) & ~statusQ & DATA_W'(16'h8E1E)) == '0));

  // R3 and R7: a nonzero vector means the line is up, zero means it is down
  p_vec_irq_r3: assert property (@(posedge clk) disable iff (!rstN)
    rdVec |-> (irqOut == (regRdData != '0)));

  // R4: enable register upper bits read as zero
  p_mask_width_r4: assert property (@(posedge clk) disable iff (!rstN)
    rdMask |-> (regRdData[DATA_W-1:MASK_W] == '0));

  // R5: enabling receive DMA drops the receive-ready enable
  p_dma_mask_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrDma && regWrData[RX_DMA_BIT]) |=> !maskQ[BIT_RRDY]);

  // R6: receive request is held low after DMA is disabled
  p_rx_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrDma && !regWrData[RX_DMA_BIT] && !clrAll) |=> !rxDmaReq);

  // R7: acknowledged bit is gone unless a set pulse hit it
  p_vec_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdVec && (regRdData != '0) && !clrAll &&
     !evtSet[regRdData[3:0] - 4'd1]) |=>
      !statusQ[$past(regRdData[3:0]) - 4'd1]);

  // R8: set pulse beats acknowledge on the same bit
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdVec && (regRdData != '0) && !clrAll &&
     evtSet[regRdData[3:0] - 4'd1]) |=>
      statusQ[$past(regRdData[3:0]) - 4'd1]);

  // R10: global clear silences every output line
  p_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    clrAll |=> (!irqOut && !rxDmaReq && !txDmaReq && (statusQ == '0)));

endmodule

bind irq_vector_unit irq_vector_unit_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MASK_W(MASK_W)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .clrAll    (clrAll),
  .evtSet    (evtSet),
  .regWrEn   (regWrEn),
  .regRdEn   (regRdEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .irqOut    (irqOut),
  .rxDmaReq  (rxDmaReq),
  .txDmaReq  (txDmaReq),
  .statusQ   (statusQ),
  .maskQ     (maskQ)
);

// File: tb/irq_vector_unit_tb.sv
module irq_vector_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clrAll = 1'b0;
  logic [15:0] evtSet = '0;
  logic        busBusy = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        irqOut, rxDmaReq, txDmaReq;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  irq_vector_unit dut_i (
    .clk(clk), .rstN(rstN), .clrAll(clrAll), .evtSet(evtSet),
    .busBusy(busBusy), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqOut(irqOut), .rxDmaReq(rxDmaReq), .txDmaReq(txDmaReq)
  );

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_EV = 2'd2, OP_OBS = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  addr;
    logic [15:0] data;
    logic [15:0] exp;
    logic [7:0]  req;
  } vec_t;

  // OBS expects {rxDmaReq, txDmaReq, irqOut}
  localparam int NVEC = 31;
  localparam vec_t TBL [NVEC] = '{
    '{OP_OBS, 4'd0, 16'h0000, 16'h0000, 8'd1},  // R1 lines low
    '{OP_RD,  4'd0, 16'h0000, 16'h0011, 8'd1},  // R1 revision
    '{OP_RD,  4'd2, 16'h0000, 16'h0000, 8'd1},  // R1 status
    '{OP_RD,  4'd1, 16'h0000, 16'h0000, 8'd1},  // R1 enable
    '{OP_RD,  4'd4, 16'h0000, 16'h0000, 8'd1},  // R1 dma
    '{OP_WR,  4'd1, 16'hFFFF, 16'h0000, 8'd4},
    '{OP_RD,  4'd1, 16'h0000, 16'h001F, 8'd4},  // R4 width
    '{OP_OBS, 4'd0, 16'h0000, 16'h0000, 8'd3},  // R3 no status, no irq
    '{OP_EV,  4'd0, 16'hFFFF, 16'h0000, 8'd2},
    '{OP_RD,  4'd2, 16'h0000, 16'h8E1E, 8'd2},  // R2 implemented bits
    '{OP_OBS, 4'd0, 16'h0000, 16'h0001, 8'd3},  // R3 irq up
    '{OP_RD,  4'd3, 16'h0000, 16'h0002, 8'd7},  // R7 lowest first
    '{OP_RD,  4'd3, 16'h0000, 16'h0003, 8'd7},  // R7 next
    '{OP_RD,  4'd2, 16'h0000, 16'h8E18, 8'd7},  // R7 bits 1,2 gone
    '{OP_WR,  4'd2, 16'h0000, 16'h0000, 8'd9},
    '{OP_WR,  4'd3, 16'hFFFF, 16'h0000, 8'd9},
    '{OP_WR,  4'd0, 16'h1234, 16'h0000, 8'd9},
    '{OP_RD,  4'd2, 16'h0000, 16'h8E18, 8'd9},  // R9 status intact
    '{OP_RD,  4'd0, 16'h0000, 16'h0011, 8'd9},  // R9 revision intact
    '{OP_WR,  4'd4, 16'hFFFF, 16'h0000, 8'd5},
    '{OP_RD,  4'd4, 16'h0000, 16'h8080, 8'd5},  // R5 kept bits
    '{OP_RD,  4'd1, 16'h0000, 16'h0007, 8'd5},  // R5 ready enables cleared
    '{OP_OBS, 4'd0, 16'h0000, 16'h0006, 8'd6},  // R6 both requests
    '{OP_RD,  4'd3, 16'h0000, 16'h0000, 8'd7},  // R7 none pending
    '{OP_WR,  4'd1, 16'h0010, 16'h0000, 8'd3},
    '{OP_OBS, 4'd0, 16'h0000, 16'h0007, 8'd3},  // R3 transmit ready enabled
    '{OP_RD,  4'd3, 16'h0000, 16'h0005, 8'd7},  // R7 bit 4
    '{OP_OBS, 4'd0, 16'h0000, 16'h0004, 8'd6},  // R6 tx drops with status
    '{OP_WR,  4'd4, 16'h0000, 16'h0000, 8'd6},
    '{OP_OBS, 4'd0, 16'h0000, 16'h0000, 8'd6},  // R6 disabled means low
    '{OP_RD,  4'd2, 16'h0000, 16'h8E08, 8'd6}   // R6 status unchanged
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic idle();
    regWrEn = 1'b0; regRdEn = 1'b0; evtSet = '0; clrAll = 1'b0;
  endtask

  task automatic doWr(input logic [3:0] a, input logic [15:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); idle();
  endtask

  task automatic doRd(input logic [3:0] a, output logic [15:0] d);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk); idle();
  endtask

  task automatic doEv(input logic [15:0] b);
    evtSet = b;
    @(negedge clk); idle();
  endtask

  function automatic logic [15:0] lines();
    return {13'd0, rxDmaReq, txDmaReq, irqOut};
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      case (TBL[i].op)
        OP_WR: doWr(TBL[i].addr, TBL[i].data);
        OP_EV: doEv(TBL[i].data);
        OP_RD: begin
          doRd(TBL[i].addr, rd);
          check($sformatf("R%0d vec%0d", TBL[i].req, i), rd, TBL[i].exp);
        end
        default: begin
          #1 check($sformatf("R%0d vec%0d", TBL[i].req, i), lines(), TBL[i].exp);
        end
      endcase
    end

    // R2: bus busy appears live in status bit 12
    busBusy = 1'b1;
    doRd(4'd2, rd);
    check("R2 busy merged", rd, 16'h9E08);
    busBusy = 1'b0;
    doRd(4'd2, rd);
    check("R2 busy dropped", rd, 16'h8E08);

    // R8: acknowledge and set pulse on bit 3 in one cycle
    doWr(4'd1, 16'h001F);
    regRdEn = 1'b1; regAddr = 4'd3; evtSet = 16'h0008;
    #1 rd = regRdData;
    @(negedge clk); idle();
    check("R8 vector value", rd, 16'h0004);
    doRd(4'd2, rd);
    check("R8 bit kept", rd, 16'h8E08);
    doRd(4'd3, rd);
    check("R7 ack again", rd, 16'h0004);
    doRd(4'd2, rd);
    check("R7 bit cleared", rd, 16'h8E00);

    // R10: global clear
    doEv(16'h0018);
    #1 check("R3 irq before clear", lines(), 16'h0001);
    clrAll = 1'b1; evtSet = 16'h8E1E;
    @(negedge clk); idle();
    doRd(4'd2, rd);
    check("R10 status zero", rd, 16'h0000);
    doRd(4'd1, rd);
    check("R10 enable zero", rd, 16'h0000);
    doRd(4'd4, rd);
    check("R10 dma zero", rd, 16'h0000);
    #1 check("R10 lines low", lines(), 16'h0000);

    summary();
    $finish;
  end

endmodule